// File: doc/BRIEF.md
# Gated Prescaled Up-Counting Timer

This block is a general-purpose up-counter with a parameterized width (32 bits by default). Software reaches it through a small register interface with three words: a configuration word, the live count and a period limit. The counter advances by one on each prescaled tick. When it reaches the period value it wraps to zero and sets a sticky match flag.

Ticks come from one of two sources. The first is the internal bus clock, where every cycle is a source event. The second is an external clock pin, where each rising edge is one source event. The internal source can be qualified by a gate input, so the timer measures how long the gate was high. The external source can go through a two-flop synchronizer before its edge is detected. A divider of 1, 8, 64 or 256 sits between the source and the counter. An idle input can freeze the timer when the idle-stop option is set. While the timer runs as a synchronized external counter, software writes to the count are dropped.

Top module: `tick_timer32`

## Requirements
- R1: After reset the configuration word, the count, the period and the match flag all read 0.
- R2: The counter advances only while the enable field (configuration bit 0) is 1. Clearing the enable field freezes the count at its current value.
- R3: The prescale field (configuration bits 5:4) selects the number of source events per tick: 0 gives 1, 1 gives 8, 2 gives 64 and 3 gives 256.
- R4: With the internal source selected (bit 2 = 0) and gating on (bit 6 = 1), source events occur only in cycles where gateIn is high. The count holds while gateIn is low.
- R5: With the internal source selected, gating off and a 1:1 prescale, the count rises by exactly one per clock cycle.
- R6: On a tick where the count equals the period, the count returns to 0 and the match flag (configuration bit 8) is set. The flag stays set until software writes the configuration word with bit 8 = 1.
- R7: While enable, external source (bit 2) and external synchronization (bit 3) are all 1, a write to the count word (address 1) is discarded. In any other configuration the write loads the count.
- R8: With idle-stop (bit 1) set, the timer is frozen in every cycle where idleIn is high. With idle-stop clear, idleIn has no effect.
- R9: With the external source selected, each rising edge on extClkIn counts as one source event. With synchronization off, the count changes on the first clock edge that sees the pin high. With synchronization on, the count changes on the third such edge.
- R10: The prescaler restarts from zero whenever the timer is disabled or the configuration word is written.
- R11: With the external source selected, the gate field and gateIn have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| idleIn | input | 1 | System idle indication |
| gateIn | input | 1 | Gate for time accumulation, synchronous to clk |
| extClkIn | input | 1 | External count pin |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Word select: 0 configuration, 1 count, 2 period |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| matchFlag | output | 1 | Sticky period-match flag |

## Verification
The assertions check several rules on every cycle:
- The count holds while the timer is disabled, gated low, idle-stopped or write-locked.
- The count steps by exactly one on a tick below the period.
- The count wraps to zero with the flag set on a tick at the period.

Other behaviour only the bench scenarios can show, because it depends on how many cycles pass between a stimulus and its effect:
- The prescale ratios.
- The two- versus zero-cycle latency of the external synchronizer.
- Restarting the prescaler on a configuration write.
- The flag staying set until it is cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PRE_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_PER  = 2'd2;

  typedef struct packed {
    logic       enable;
    logic       idleStop;
    logic       extSel;
    logic       extSync;
    logic [1:0] prescale;
    logic       gateEn;
  } tmr_cfg_t;

  typedef struct packed {
    logic tick;
    logic cntLoad;
    logic perLoad;
    logic flagClr;
  } tmr_strobe_t;

  function automatic logic [PRE_W-1:0] preLast(input logic [1:0] sel);
    case (sel)
      2'd0:    preLast = PRE_W'(0);
      2'd1:    preLast = PRE_W'(7);
      2'd2:    preLast = PRE_W'(63);
      default: preLast = PRE_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extIn,
  input  logic useSync,
  output logic edgeEvt
);

  logic [SYNC_STAGES-1:0] chain;
  logic syncPrev;
  logic rawPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= extIn;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], extIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      rawPrev  <= 1'b0;
    end else begin
      syncPrev <= chain[SYNC_STAGES-1];
      rawPrev  <= extIn;
    end
  end

  always_comb begin
    if (useSync) edgeEvt = chain[SYNC_STAGES-1] & ~syncPrev;
    else         edgeEvt = extIn & ~rawPrev;
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       srcEvt,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] lastVal;

  assign lastVal = preLast(sel);
  assign tick    = srcEvt && !clr && (preCnt == lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       preCnt <= '0;
    else if (clr)    preCnt <= '0;
    else if (srcEvt) preCnt <= (preCnt == lastVal) ? '0 : preCnt + 1'b1;
  end

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        idleIn,
  input  logic        gateIn,
  input  logic        extClkIn,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [7:0]  ctrlData,
  output tmr_cfg_t    cfgQ,
  output tmr_strobe_t stb
);

  logic ctrlWr;
  logic lockout;
  logic running;
  logic extEvt;
  logic srcEvt;
  logic preClr;
  logic tickRaw;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (ctrlWr) begin
      cfgQ.enable   <= ctrlData[0];
      cfgQ.idleStop <= ctrlData[1];
      cfgQ.extSel   <= ctrlData[2];
      cfgQ.extSync  <= ctrlData[3];
      cfgQ.prescale <= ctrlData[5:4];
      cfgQ.gateEn   <= ctrlData[6];
    end
  end

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .extIn   (extClkIn),
    .useSync (cfgQ.extSync),
    .edgeEvt (extEvt)
  );

  assign running = cfgQ.enable && !(cfgQ.idleStop && idleIn);

  always_comb begin
    if (cfgQ.extSel)      srcEvt = extEvt;
    else if (cfgQ.gateEn) srcEvt = gateIn;
    else                  srcEvt = 1'b1;
    srcEvt = srcEvt && running;
  end

  assign preClr = !cfgQ.enable || ctrlWr;

  tmr_prescaler u_pre (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (preClr),
    .srcEvt (srcEvt),
    .sel    (cfgQ.prescale),
    .tick   (tickRaw)
  );

  assign lockout = cfgQ.enable && cfgQ.extSel && cfgQ.extSync;

  always_comb begin
    stb.tick    = tickRaw;
    stb.cntLoad = wrEn && (addr == ADDR_CNT) && !lockout;
    stb.perLoad = wrEn && (addr == ADDR_PER);
    stb.flagClr = ctrlWr && ctrlData[7];
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmr_strobe_t  stb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] countQ,
  output logic [W-1:0] periodQ,
  output logic         flagQ
);

  logic wrapNow;

  assign wrapNow = stb.tick && !stb.cntLoad && (countQ == periodQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            countQ <= '0;
    else if (stb.cntLoad) countQ <= wrData;
    else if (wrapNow)     countQ <= '0;
    else if (stb.tick)    countQ <= countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            periodQ <= '0;
    else if (stb.perLoad) periodQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (wrapNow)     flagQ <= 1'b1;
    else if (stb.flagClr) flagQ <= 1'b0;
  end

endmodule

// File: rtl/tick_timer32.sv
module tick_timer32
  import tmr_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         idleIn,
  input  logic         gateIn,
  input  logic         extClkIn,
  input  logic         wrEn,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         matchFlag
);

  localparam int CFG_BITS = 9;

  tmr_cfg_t    cfgQ;
  tmr_strobe_t stb;
  logic [W-1:0] countVal;
  logic [W-1:0] periodVal;
  logic [CFG_BITS-1:0] cfgWord;

  tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .idleIn   (idleIn),
    .gateIn   (gateIn),
    .extClkIn (extClkIn),
    .wrEn     (wrEn),
    .addr     (addr),
    .ctrlData ({wrData[8], wrData[6:0]}),
    .cfgQ     (cfgQ),
    .stb      (stb)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .countQ  (countVal),
    .periodQ (periodVal),
    .flagQ   (matchFlag)
  );

  assign cfgWord = {matchFlag, 1'b0, cfgQ.gateEn, cfgQ.prescale,
                    cfgQ.extSync, cfgQ.extSel, cfgQ.idleStop, cfgQ.enable};

  always_comb begin
    case (addr)
      ADDR_CTRL: rdData = W'(cfgWord);
      ADDR_CNT:  rdData = countVal;
      ADDR_PER:  rdData = periodVal;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input logic         idleStop,
  input logic         extSel,
  input logic         extSync,
  input logic         gateEn,
  input logic         idleIn,
  input logic         gateIn,
  input logic         wrEn,
  input logic [1:0]   addr,
  input logic         tick,
  input logic         cntLoad,
  input logic [W-1:0] countVal,
  input logic [W-1:0] periodVal,
  input logic         matchFlag
);

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cntLoad) |=> $stable(countVal));

  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntLoad && countVal != periodVal) |=> countVal == $past(countVal) + 1'b1);

  a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntLoad && countVal == periodVal) |=> (countVal == '0) && matchFlag);

  a_r7_write_locked: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && enable && extSel && extSync && !tick) |=> $stable(countVal));

  a_r4_gate_low_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!extSel && gateEn && !gateIn && !cntLoad) |=> $stable(countVal));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (idleStop && idleIn && !cntLoad) |=> $stable(countVal));

endmodule

bind tick_timer32 tmr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (cfgQ.enable),
  .idleStop  (cfgQ.idleStop),
  .extSel    (cfgQ.extSel),
  .extSync   (cfgQ.extSync),
  .gateEn    (cfgQ.gateEn),
  .idleIn    (idleIn),
  .gateIn    (gateIn),
  .wrEn      (wrEn),
  .addr      (addr),
  .tick      (stb.tick),
  .cntLoad   (stb.cntLoad),
  .countVal  (countVal),
  .periodVal (periodVal),
  .matchFlag (matchFlag)
);

// File: tb/sim_tick_timer32.sv
`timescale 1ns/1ps
module sim_tick_timer32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        idleIn = 1'b0;
  logic        gateIn = 1'b0;
  logic        extClkIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        matchFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_timer32 u0 (
    .clk(clk), .rstN(rstN), .idleIn(idleIn), .gateIn(gateIn),
    .extClkIn(extClkIn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .matchFlag(matchFlag)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 2'd0; wrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
    addr = 2'd0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; idleIn = 1'b0; gateIn = 1'b0; extClkIn = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic extPulse();
    extClkIn = 1'b1; cyc(2);
    extClkIn = 1'b0; cyc(2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    doReset();
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd2, v); check("R1 period", v, 0);
    check("R1 flag", matchFlag, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    cyc(4);
    rd(2'd1, v); check("R2 disabled holds", v, 0);
    wr(2'd0, 32'h1);
    cyc(10);
    rd(2'd1, v); check("R5 one per cycle", v, 10);
    wr(2'd0, 32'h0);
    cyc(5);
    rd(2'd1, v); check("R2 stop freezes", v, 11);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    for (int s = 1; s < 4; s++) begin
      int div;
      div = (s == 1) ? 8 : (s == 2) ? 64 : 256;
      doReset();
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, 32'h1 | (s << 4));
      cyc(3 * div - 1);
      rd(2'd1, v); check("R3 before tick", v, 2);
      cyc(1);
      rd(2'd1, v); check("R3 on tick", v, 3);
    end
  endtask

  task automatic t_period();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'd3);
    wr(2'd0, 32'h1);
    cyc(3);
    rd(2'd1, v); check("R6 at period", v, 3);
    check("R6 flag clear before", matchFlag, 0);
    cyc(1);
    rd(2'd1, v); check("R6 wrap", v, 0);
    check("R6 flag set", matchFlag, 1);
    cyc(2);
    check("R6 flag sticky", matchFlag, 1);
    wr(2'd0, 32'h101);
    check("R6 flag cleared", matchFlag, 0);
    rd(2'd1, v); check("R6 count after clear", v, 3);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h41);
    cyc(6);
    rd(2'd1, v); check("R4 gate low", v, 0);
    gateIn = 1'b1; cyc(5);
    gateIn = 1'b0;
    rd(2'd1, v); check("R4 gate high", v, 5);
    cyc(4);
    rd(2'd1, v); check("R4 gate low again", v, 5);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h45);
    extClkIn = 1'b1; cyc(1);
    rd(2'd1, v); check("R9 raw edge immediate", v, 1);
    extClkIn = 1'b0; cyc(2);
    for (int i = 0; i < 3; i++) extPulse();
    rd(2'd1, v); check("R11 gate ignored on ext", v, 4);
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0D);
    extClkIn = 1'b1; cyc(1);
    rd(2'd1, v); check("R9 sync latency", v, 0);
    cyc(2);
    rd(2'd1, v); check("R9 sync edge", v, 1);
    extClkIn = 1'b0; cyc(2);
    for (int i = 0; i < 4; i++) extPulse();
    cyc(4);
    rd(2'd1, v); check("R9 sync count", v, 5);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0D);
    wr(2'd1, 32'd100);
    rd(2'd1, v); check("R7 write dropped", v, 0);
    wr(2'd0, 32'h05);
    wr(2'd1, 32'd100);
    rd(2'd1, v); check("R7 unsync accepts", v, 100);
    wr(2'd0, 32'h0C);
    wr(2'd1, 32'd50);
    rd(2'd1, v); check("R7 disabled accepts", v, 50);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    idleIn = 1'b1;
    wr(2'd0, 32'h3);
    cyc(5);
    rd(2'd1, v); check("R8 idle stop", v, 0);
    idleIn = 1'b0; cyc(3);
    rd(2'd1, v); check("R8 resume", v, 3);
    idleIn = 1'b1;
    wr(2'd0, 32'h1);
    cyc(4);
    rd(2'd1, v); check("R8 idle ignored", v, 7);
    idleIn = 1'b0;
  endtask

  task automatic t_preReset();
    logic [31:0] v;
    doReset();
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h11);
    cyc(5);
    wr(2'd0, 32'h11);
    cyc(7);
    rd(2'd1, v); check("R10 restart on write", v, 0);
    cyc(1);
    rd(2'd1, v); check("R10 first tick", v, 1);
    cyc(5);
    wr(2'd0, 32'h10);
    wr(2'd0, 32'h11);
    cyc(7);
    rd(2'd1, v); check("R10 restart on disable", v, 1);
    cyc(1);
    rd(2'd1, v); check("R10 tick after disable", v, 2);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prescale();
    t_period();
    t_gate();
    t_ext();
    t_lock();
    t_idle();
    t_preReset();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule